// File: doc/BRIEF.md
# Completion Status Read Queue

This block is the read side of a memory-mapped slave through which a host polls for engine completion. Each time an engine finishes, logic inside the chip presents a 64-bit status word on a valid/data push port, and the word is stored in a synchronous first-in first-out queue. The host issues AXI-Lite reads. Each accepted read address takes the oldest stored word off the queue and returns it on the read data channel.

The queue never pushes back on the producer. A word that arrives while every entry is occupied is thrown away without any error indication. This is acceptable because status words repeat information that a later poll will see again. The read address channel is accepted only when at least one word is stored and the previous read response has been taken by the host. As a result, at most one response is ever outstanding.

Top module: `stq_axil_read`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the queue is emptied and `s_rvalid` is cleared. After reset, `s_arready` and `s_rvalid` are both 0.
- R2: A cycle with `stat_push` high and the queue not full stores `stat_word`. Reads return stored words in the order they were pushed.
- R3: A push that arrives while the queue holds DEPTH words (default 8) and no read address is accepted in that cycle is discarded. Later reads return only the earlier words.
- R4: `s_arready` is 0 whenever the queue holds no word.
- R5: `s_arready` is 0 whenever `s_rvalid` is 1.
- R6: When a read address is accepted (`s_arvalid` and `s_arready` both high at an edge), `s_rvalid` is 1 from that edge on, and `s_rdata` equals the oldest stored word. That word leaves the queue at the same edge.
- R7: While `s_rvalid` is 1 and `s_rready` is 0, `s_rvalid` and `s_rdata` keep their values.
- R8: A response is taken at an edge where `s_rvalid` and `s_rready` are both 1, and `s_rvalid` is 0 after that edge.
- R9: `s_rresp` is always 2'b00 (OKAY) while `s_rvalid` is 1.
- R10: When a push and an accepted read address coincide on a full queue, the push is stored. The queue stays full, and the new word is returned after the words already stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| stat_push | input | 1 | Status word push strobe |
| stat_word | input | DATA_W (64) | Status word to store |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W (64) | Read data |
| s_rresp | output | 2 | Read response, always OKAY |

## Verification
The hardest case to reach is a push that lands in the same cycle as an accepted read address while the queue is full. Read addresses are only accepted when no response is pending, so that condition requires a full queue, an idle response channel and a push, all in one cycle. The stimulus fills the queue with exactly DEPTH words, lets the response channel drain, and then raises the push and the read address together. It then reads every remaining word to show that the new word came out last. A separate overfill phase pushes DEPTH+2 words into an empty queue with no reads, to show that the extra two words never appear.

// File: rtl/stq_pkg.sv
package stq_pkg;
   localparam logic [1:0] RESP_OKAY = 2'b00;

   typedef enum logic {
      RSP_IDLE = 1'b0,
      RSP_HELD = 1'b1
   } rsp_state_e;
endpackage

// File: rtl/stq_fifo.sv
module stq_fifo #(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;

   initial begin
      assert (DEPTH >= 2) else $error("stq_fifo: DEPTH must be at least 2");
      assert (DATA_W >= 1) else $error("stq_fifo: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_ptr_nxt, rd_ptr_nxt;
   logic [CNT_W-1:0]  count;
   logic              full, wr_en;

   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);
   // a pop in the same cycle frees a slot, so a full queue still takes the word
   assign wr_en = wr_req && (!full || rd_en);
   assign rd_data = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_free
         assign wr_ptr_nxt = wr_ptr + PTR_W'(1);
         assign rd_ptr_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign wr_ptr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_ptr_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr_nxt;
         if (rd_en) rd_ptr <= rd_ptr_nxt;
         case ({wr_en, rd_en})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/stq_rd_port.sv
module stq_rd_port #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q_empty,
   input  logic [DATA_W-1:0] q_head,
   output logic              q_pop,
   input  logic              arvalid,
   output logic              arready,
   output logic              rvalid,
   input  logic              rready,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp
);
   import stq_pkg::*;

   rsp_state_e        state;
   logic [DATA_W-1:0] rdata_q;

   assign arready = !q_empty && (state == RSP_IDLE);
   assign q_pop   = arvalid && arready;
   assign rvalid  = (state == RSP_HELD);
   assign rdata   = rdata_q;
   assign rresp   = RESP_OKAY;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= RSP_IDLE;
         rdata_q <= '0;
      end else begin
         case (state)
            RSP_IDLE: if (q_pop) begin
               state   <= RSP_HELD;
               rdata_q <= q_head;
            end
            RSP_HELD: if (rready) state <= RSP_IDLE;
            default:  state <= RSP_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/stq_axil_read.sv
module stq_axil_read #(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_push,
   input  logic [DATA_W-1:0] stat_word,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp
);
   logic              q_empty, q_pop;
   logic [DATA_W-1:0] q_head;

   stq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (stat_push),
      .wr_data (stat_word),
      .rd_en   (q_pop),
      .rd_data (q_head),
      .empty   (q_empty)
   );

   stq_rd_port #(.DATA_W(DATA_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .q_empty (q_empty),
      .q_head  (q_head),
      .q_pop   (q_pop),
      .arvalid (s_arvalid),
      .arready (s_arready),
      .rvalid  (s_rvalid),
      .rready  (s_rready),
      .rdata   (s_rdata),
      .rresp   (s_rresp)
   );
endmodule

// File: rtl/stq_axil_read_chk.sv
module stq_axil_read_chk #(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stat_push,
   input logic [DATA_W-1:0] stat_word,
   input logic              s_arvalid,
   input logic              s_arready,
   input logic              s_rvalid,
   input logic              s_rready,
   input logic [DATA_W-1:0] s_rdata,
   input logic [1:0]        s_rresp
);
   localparam int OCC_W = $clog2(DEPTH + 1) + 1;

   logic [OCC_W-1:0] occ;
   logic             ar_hs, take;
   logic [DATA_W-1:0] unused_word;

   assign unused_word = stat_word;
   assign ar_hs = s_arvalid && s_arready;
   assign take  = stat_push && ((occ < OCC_W'(DEPTH)) || ar_hs);

   always_ff @(posedge clk) begin
      if (!rst_n) occ <= '0;
      else occ <= occ + OCC_W'(take) - OCC_W'(ar_hs);
   end

   // R4
   no_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0) |-> !s_arready);
   // R5
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_rvalid |-> !s_arready);
   // R6
   ar_to_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ar_hs |=> s_rvalid);
   // R7
   r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));
   // R8
   r_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rvalid && s_rready) |=> !s_rvalid);
   // R9
   resp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_rvalid |-> (s_rresp == 2'b00));
   // R3
   occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= OCC_W'(DEPTH));
endmodule

bind stq_axil_read stq_axil_read_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/stq_axil_read_test.sv
module stq_axil_read_test;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 64;
   localparam int DEPTH      = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              stat_push = 1'b0;
   logic [DATA_W-1:0] stat_word = '0;
   logic              s_arvalid = 1'b0;
   logic              s_arready;
   logic              s_rvalid;
   logic              s_rready = 1'b0;
   logic [DATA_W-1:0] s_rdata;
   logic [1:0]        s_rresp;

   int checks = 0;
   int fails  = 0;
   int occ    = 0;
   logic [DATA_W-1:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   stq_axil_read #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (.*);

   task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                      input logic [DATA_W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: compares every completed response against the scoreboard
   always @(negedge clk) begin
      if (rst_n && s_rvalid && s_rready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected response", s_rdata, '0);
         end else begin
            logic [DATA_W-1:0] e;
            e = exp_q.pop_front();
            chk(s_rdata == e, "R2 response order", s_rdata, e);
            chk(s_rresp == 2'b00, "R9 resp OKAY", DATA_W'(s_rresp), '0);
         end
      end
   end

   // driver tasks start and end at posedge + 1
   task automatic push_word(input logic [DATA_W-1:0] d);
      stat_push = 1'b1;
      stat_word = d;
      @(posedge clk); #1;
      stat_push = 1'b0;
      if (occ < DEPTH) begin
         occ++;
         exp_q.push_back(d);
      end
   endtask

   task automatic read_one(input int hold, input bit with_push, input logic [DATA_W-1:0] d);
      bit ok;
      logic [DATA_W-1:0] first;
      s_arvalid = 1'b1;
      if (with_push) begin
         stat_push = 1'b1;
         stat_word = d;
      end
      ok = 1'b0;
      for (int i = 0; i < 50 && !ok; i++) begin
         @(negedge clk);
         ok = s_arready;
         @(posedge clk); #1;
      end
      s_arvalid = 1'b0;
      stat_push = 1'b0;
      chk(ok, "R6 read address accepted", DATA_W'(ok), 1);
      occ--;
      if (with_push) begin
         occ++;
         exp_q.push_back(d);
      end
      @(negedge clk);
      chk(s_rvalid == 1'b1, "R6 rvalid after AR", DATA_W'(s_rvalid), 1);
      chk(s_arready == 1'b0, "R5 arready low while response held", DATA_W'(s_arready), 0);
      first = s_rdata;
      for (int i = 0; i < hold; i++) begin
         @(posedge clk); #1;
         @(negedge clk);
         chk(s_rvalid == 1'b1, "R7 rvalid held", DATA_W'(s_rvalid), 1);
         chk(s_rdata == first, "R7 rdata held", s_rdata, first);
      end
      @(posedge clk); #1;
      s_rready = 1'b1;
      @(posedge clk); #1;
      s_rready = 1'b0;
      @(negedge clk);
      chk(s_rvalid == 1'b0, "R8 rvalid cleared", DATA_W'(s_rvalid), 0);
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(s_arready == 1'b0, "R1 arready after reset", DATA_W'(s_arready), 0);
      chk(s_rvalid == 1'b0, "R1 rvalid after reset", DATA_W'(s_rvalid), 0);
      chk(s_arready == 1'b0, "R4 no read on empty", DATA_W'(s_arready), 0);
      @(posedge clk); #1;

      // R2: basic push and read, with varied hold times (R7)
      push_word(64'hA5A5_0000_0000_0001);
      push_word(64'h0123_4567_89AB_CDEF);
      read_one(0, 1'b0, '0);
      read_one(3, 1'b0, '0);
      @(negedge clk);
      chk(s_arready == 1'b0, "R4 empty after draining", DATA_W'(s_arready), 0);
      @(posedge clk); #1;

      // R3: overfill with DEPTH+2 words, extras dropped
      for (int i = 0; i < DEPTH + 2; i++) push_word(64'h3000 + 64'(i));
      for (int i = 0; i < DEPTH; i++) read_one(i % 3, 1'b0, '0);
      @(negedge clk);
      chk(s_arready == 1'b0, "R3 dropped words absent", DATA_W'(s_arready), 0);
      chk(exp_q.size() == 0, "R3 scoreboard drained", DATA_W'(exp_q.size()), 0);
      @(posedge clk); #1;

      // R10: push together with a pop on a full queue
      for (int i = 0; i < DEPTH; i++) push_word(64'h1000_0000 + 64'(i));
      read_one(1, 1'b1, 64'hFEED_FACE_0000_0010);
      for (int i = 0; i < DEPTH; i++) read_one(0, 1'b0, '0);
      @(negedge clk);
      chk(exp_q.size() == 0, "R10 pushed word returned last", DATA_W'(exp_q.size()), 0);
      chk(s_arready == 1'b0, "R10 queue empty afterwards", DATA_W'(s_arready), 0);
      @(posedge clk); #1;

      // R1: reset mid-run empties the queue and clears a held response
      push_word(64'h5555);
      push_word(64'h6666);
      s_arvalid = 1'b1;
      @(posedge clk); #1;
      s_arvalid = 1'b0;
      rst_n = 1'b0;
      @(posedge clk); #1;
      rst_n = 1'b1;
      exp_q.delete();
      occ = 0;
      @(negedge clk);
      chk(s_rvalid == 1'b0, "R1 rvalid cleared by reset", DATA_W'(s_rvalid), 0);
      chk(s_arready == 1'b0, "R1 queue emptied by reset", DATA_W'(s_arready), 0);
      @(posedge clk); #1;
      push_word(64'h7777);
      read_one(0, 1'b0, '0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule